// File: doc/BRIEF.md
# Chip-Select Bank Decode and Timing

This block serves one external memory bank. It compares each requested bus address against a programmable base word. An option word masks which upper address bits take part in that comparison. When an access matches, the block drives the active-low chip-select, write-enable and data-buffer-control strobes, and it raises a done indication.

The block runs on a clock four times the bus clock. A free-running 2-bit phase counter splits each bus clock into four quarters, and every strobe edge is registered on a quarter boundary. An accepted access lasts two bus clocks, which is eight quarters. The setup code in the option word sets the quarter in which chip-select first asserts. The early-release bit pulls chip-select and write-enable off one quarter early on writes. The buffer-disable bit keeps the buffer control strobe quiet.

Option word layout, with bit 31 as the most significant:
- [31:15] holds the mask for address bits [31:15].
- [14:13] is reserved.
- [12] is buffer-disable.
- [11] is early-release.
- [10:9] is the setup code.

Top module: `csbank_timing`

## Requirements
- R1: An access is a hit when `(addr[31:15] ^ base[31:15]) & opt[31:15]` is zero. A mask bit of 1 compares that address bit, and a mask bit of 0 ignores it.
- R2: Mask bits may form any pattern. A mask with a cleared middle bit makes the bank answer in two address regions that differ only in that bit.
- R3: In an access, quarters are numbered q = 0..7 starting from the first quarter after acceptance. Chip-select asserts at q=0 for setup code 00, at q=1 for code 10 and at q=2 for code 11.
- R4: Setup code 01 times exactly like 00. While the option word holds 01, `cfg_err` is 1; otherwise `cfg_err` is 0.
- R5: On a write with early-release (opt[11]) set, chip-select and write-enable are released at q=7. Otherwise they stay asserted through q=7. Early-release has no effect on reads.
- R6: Write-enable asserts only for write accesses, and only while chip-select is asserted.
- R7: With buffer-disable (opt[12]) set, the buffer control stays high. With it clear, the buffer control is low for all of q=0..7.
- R8: Option bits [14:13] always read back as zero.
- R9: After reset, the option word reads 0xFE000EF4, the base reads 0, all strobes are inactive and `cfg_err` is 0.
- R10: `done` is high during the final bus clock of an access (q=4..7). All outputs are idle from q=8 on.
- R11: A start request that misses drives no strobe and no `done`.
- R12: A start request is accepted only on a clock edge where `phase` is 3 and no access is in progress. Requests seen on other edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-phase clock (4x bus clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the base word, 1 selects the option word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected configuration word |
| cfg_err | output | 1 | Reserved setup code programmed |
| req_start | input | 1 | Access request |
| req_write | input | 1 | 1 = write access |
| req_addr | input | 32 | Access address |
| phase | output | 2 | Current quarter of the bus clock |
| cs_n | output | 1 | Chip-select, active low |
| we_n | output | 1 | Write-enable, active low |
| bctl_n | output | 1 | Data buffer control, active low |
| done | output | 1 | Final bus clock of an access |

## Verification
Two features can act on the same quarter: the late setup of chip-select and its early release on writes. Both are tied to the same access counter. The bench runs every setup code against both early-release settings on reads and on writes, and it checks all four strobes at every quarter against a bench model, so a start or end edge that lands one quarter off shows up as a miscompare. It also checks that a request held through phases 0 to 2 and dropped before phase 3 produces nothing.

// File: rtl/csbank_timing.sv
module csbank_timing #(
  parameter logic [31:0] BASE_RST = 32'h0000_0000,
  parameter logic [31:0] OPT_RST  = 32'hFE00_0EF4
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_err,
  input  logic        req_start,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  output logic [1:0]  phase,
  output logic        cs_n,
  output logic        we_n,
  output logic        bctl_n,
  output logic        done
);
  localparam logic [31:0] RSV_M = 32'h0000_6000;
  localparam int          LAST_Q = 7;

  logic [31:0] base_q, opt_q;
  logic        busy, wr_q, early_q, nob_q;
  logic [2:0]  q;
  logic [1:0]  s_q, s_cfg, cur_s;
  logic        hit, take, n_busy, cur_wr, cur_early, cur_nob;
  logic        n_cs, n_we, n_bctl, n_done;
  logic [2:0]  n_q;

  assign hit  = ((req_addr[31:15] ^ base_q[31:15]) & opt_q[31:15]) == '0;
  assign take = req_start & ~busy & (phase == 2'd3) & hit;

  always_comb
    case (opt_q[10:9])
      2'b10:   s_cfg = 2'd1;
      2'b11:   s_cfg = 2'd2;
      default: s_cfg = 2'd0;
    endcase

  assign n_busy    = take | (busy & (q != 3'(LAST_Q)));
  assign n_q       = take ? 3'd0 : q + 3'd1;
  assign cur_s     = take ? s_cfg : s_q;
  assign cur_wr    = take ? req_write : wr_q;
  assign cur_early = take ? (req_write & opt_q[11]) : early_q;
  assign cur_nob   = take ? opt_q[12] : nob_q;

  assign n_cs   = n_busy & (n_q >= {1'b0, cur_s}) & ~(cur_early & (n_q == 3'(LAST_Q)));
  assign n_we   = n_cs & cur_wr;
  assign n_bctl = n_busy & ~cur_nob;
  assign n_done = n_busy & n_q[2];

  assign cfg_rdata = cfg_sel ? opt_q : base_q;
  assign cfg_err   = opt_q[10:9] == 2'b01;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= 2'd0;
      base_q  <= BASE_RST;
      opt_q   <= OPT_RST & ~RSV_M;
      busy    <= 1'b0;
      q       <= 3'd0;
      wr_q    <= 1'b0;
      early_q <= 1'b0;
      nob_q   <= 1'b0;
      s_q     <= 2'd0;
      cs_n    <= 1'b1;
      we_n    <= 1'b1;
      bctl_n  <= 1'b1;
      done    <= 1'b0;
    end else begin
      phase <= phase + 2'd1;
      if (cfg_we) begin
        if (cfg_sel) opt_q  <= cfg_wdata & ~RSV_M;
        else         base_q <= cfg_wdata;
      end
      busy <= n_busy;
      q    <= n_q;
      if (take) begin
        wr_q    <= req_write;
        early_q <= req_write & opt_q[11];
        nob_q   <= opt_q[12];
        s_q     <= s_cfg;
      end
      cs_n   <= ~n_cs;
      we_n   <= ~n_we;
      bctl_n <= ~n_bctl;
      done   <= n_done;
    end

  a_r6_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n);
  a_r3_cs_only_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  a_r7_bctl_only_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    !bctl_n |-> busy);
  a_r10_done_before_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  a_r12_start_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (phase == 2'd0));
  a_r11_start_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hit));
endmodule

// File: tb/csbank_timing_tb.sv
module csbank_timing_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic cfg_err;
  logic req_start = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0] phase;
  logic cs_n, we_n, bctl_n, done;

  int vecs = 0, errs = 0;
  logic [31:0] m_base, m_opt;

  always #(CLK_PERIOD/2) clk = ~clk;

  csbank_timing u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .req_start(req_start), .req_write(req_write), .req_addr(req_addr),
    .phase(phase), .cs_n(cs_n), .we_n(we_n), .bctl_n(bctl_n), .done(done));

  function automatic logic model_hit(logic [31:0] a);
    return ((a[31:15] ^ m_base[31:15]) & m_opt[31:15]) == '0;
  endfunction

  // returns active-low {cs_n, we_n, bctl_n} and done
  function automatic logic [3:0] model_out(int qq, logic h, logic wr);
    int s;
    logic cs, early;
    case (m_opt[10:9]) 2'b10: s = 1; 2'b11: s = 2; default: s = 0; endcase
    early = wr & m_opt[11];
    cs = h && qq < 8 && qq >= s && !(early && qq == 7);
    return {~cs, ~(cs & wr), ~(h && qq < 8 && !m_opt[12]), h && qq >= 4 && qq < 8};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wcfg(logic sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) m_opt = d & ~32'h6000; else m_base = d;
  endtask

  task automatic access(logic [31:0] a, logic wr, string tag);
    logic h;
    h = model_hit(a);
    @(negedge clk);
    while (phase != 2'd3) @(negedge clk);
    req_start = 1'b1; req_addr = a; req_write = wr;
    for (int qq = 0; qq <= 8; qq++) begin
      @(negedge clk);
      req_start = 1'b0;
      chk($sformatf("%s q=%0d a=%h wr=%0b opt=%h", tag, qq, a, wr, m_opt),
          {28'd0, cs_n, we_n, bctl_n, done}, {28'd0, model_out(qq, h, wr)});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    m_base = 32'h0; m_opt = 32'hFE00_0EF4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_sel = 1'b1; #1 chk("R9 opt reset", cfg_rdata, 32'hFE00_0EF4);
    cfg_sel = 1'b0; #1 chk("R9 base reset", cfg_rdata, 32'h0);
    chk("R9 idle strobes", {28'd0, cs_n, we_n, bctl_n, done}, 32'he);
    chk("R9 cfg_err", {31'd0, cfg_err}, 32'd0);

    // R8 reserved bits
    wcfg(1'b1, 32'hFFFF_FFFF);
    cfg_sel = 1'b1; #1 chk("R8 reserved read zero", cfg_rdata, 32'hFFFF_9FFF);

    // R3 R4 R5 R6 R7: all setup codes x early-release x direction
    wcfg(1'b0, 32'h2000_0000);
    for (int c = 0; c < 4; c++)
      for (int e = 0; e < 2; e++)
        for (int w = 0; w < 2; w++) begin
          wcfg(1'b1, {17'h1FFFF, 2'b11, 1'b0, e[0], c[1:0], 9'h0});
          chk($sformatf("R4 cfg_err code=%0d", c), {31'd0, cfg_err}, {31'd0, c == 1});
          access(32'h2000_1234, w[0], "R3/R4/R5/R6/R10 timing");
        end
    wcfg(1'b1, {17'h1FFFF, 2'b00, 1'b1, 1'b1, 2'b11, 9'h0});
    access(32'h2000_0000, 1'b1, "R7 buffer disabled write");
    access(32'h2000_0000, 1'b0, "R7 buffer disabled read");

    // R2 aliasing: mask ignores addr[20]
    wcfg(1'b0, 32'h4000_0000);
    wcfg(1'b1, {17'h1FFDF, 2'b00, 1'b0, 1'b0, 2'b00, 9'h0});
    access(32'h4000_0000, 1'b0, "R2 region A");
    access(32'h4010_0000, 1'b1, "R2 region B");
    access(32'h4020_0000, 1'b0, "R2/R11 outside");
    access(32'h5000_0000, 1'b1, "R11 miss");

    // R12 request dropped before phase 3
    @(negedge clk);
    while (phase != 2'd0) @(negedge clk);
    req_start = 1'b1; req_addr = 32'h4000_0000; req_write = 1'b1;
    repeat (3) @(negedge clk);
    req_start = 1'b0;
    for (int qq = 0; qq < 9; qq++) begin
      @(negedge clk);
      chk("R12 off-phase request ignored", {28'd0, cs_n, we_n, bctl_n, done}, 32'he);
    end

    // R1 random masks, bases and addresses
    for (int t = 0; t < 60; t++) begin
      logic [31:0] a;
      wcfg(1'b0, $urandom);
      wcfg(1'b1, {$urandom} & 32'hFFFF_9E00);
      a = $urandom;
      if ($urandom % 2)
        a = (m_base & {m_opt[31:15], 15'h0}) | (a & ~{m_opt[31:15], 15'h0});
      access(a, 1'($urandom), "R1 random decode");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule